// File: doc/BRIEF.md
# Time-of-Year Tag Counter

This block keeps a running time of year that other logic uses to stamp bus events. The time is split into five fields: day of year, hour, minute, second and microsecond. It advances by one microsecond after every ten strobes of the chosen 10 MHz reference. The reference is either an on-board strobe or a backplane strobe, picked by a select pin. Each strobe is a single-cycle pulse in the `clk` domain, already synchronized upstream.

A host can preset all five fields at once with a load strobe. A backplane star pulse returns the time to day 1, 00:00:00.000000, but only while the counter is free-wheeling. While `ext_sync` shows that the time follows an external time code, star pulses are ignored.

The time is read out as two 32-bit words on a valid/ready output stream. A single-cycle `rd_req` takes a snapshot of the whole tag in one cycle. The stream then presents that snapshot with `tag_valid` high. While `tag_valid` is high and `tag_ready` is low, the words are held unchanged and a further `rd_req` is dropped. The transfer completes in any cycle where `tag_valid` and `tag_ready` are both high. A new `rd_req` in that same cycle loads the next snapshot straight away.

Top module: `tt_timetag`

## Requirements
- R1: After reset the tag reads as day 1 with hour, minute, second and microsecond all zero, and `tag_valid` is low.
- R2: The microsecond field advances by one after every 10 strobes of the selected reference (`ref_sel` = 0 picks `ref_int_stb`, 1 picks `ref_bp_stb`). Strobes on the reference that is not selected have no effect.
- R3: The microsecond field counts 0 to 999999. On the next microsecond it wraps to 0 and the second field goes up by one.
- R4: Seconds and minutes wrap from 59 to 0, and hours wrap from 23 to 0. Each wrap adds one to the next larger field in the same update.
- R5: The day field counts 1 to 366 and wraps to 1 when hour 23:59:59.999999 of day 366 ends.
- R6: A `load_stb` cycle writes all five load fields into the tag. It also restarts the count of reference strobes toward the next microsecond from zero.
- R7: When `ext_sync` is 0, a `star_pulse` cycle sets the tag to day 1 with all lower fields zero. It also restarts the strobe count from zero.
- R8: When `ext_sync` is 1, `star_pulse` has no effect on the tag.
- R9: When `star_pulse` (with `ext_sync` = 0) and `load_stb` occur in the same cycle, the tag is cleared to day 1 and the load data is discarded.
- R10: `tag_hi` carries day in bits 19:11, hour in bits 10:6 and minute in bits 5:0. `tag_lo` carries second in bits 25:20 and microsecond in bits 19:0. All other bits are zero.
- R11: `rd_req` captures both words in one cycle. While `tag_valid` is high and `tag_ready` is low, `tag_valid` stays high and both words stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_sel | input | 1 | Reference select: 0 on-board strobe, 1 backplane strobe |
| ref_int_stb | input | 1 | On-board 10 MHz reference strobe |
| ref_bp_stb | input | 1 | Backplane 10 MHz reference strobe |
| ext_sync | input | 1 | 1 while the time follows an external time code |
| star_pulse | input | 1 | Backplane clear-to-day-1 pulse |
| load_stb | input | 1 | Preset strobe for all fields |
| load_day | input | 9 | Preset day of year (1 to 366) |
| load_hour | input | 5 | Preset hour (0 to 23) |
| load_min | input | 6 | Preset minute (0 to 59) |
| load_sec | input | 6 | Preset second (0 to 59) |
| load_usec | input | 20 | Preset microsecond (0 to 999999) |
| rd_req | input | 1 | Snapshot request |
| tag_valid | output | 1 | Snapshot words valid |
| tag_ready | input | 1 | Consumer accepts snapshot |
| tag_hi | output | 32 | Day, hour and minute word |
| tag_lo | output | 32 | Second and microsecond word |

## Verification
The field range assertions assume that every preset value lies inside its field's legal range. The bench only ever loads legal values, including the upper limits of every field. The single-cycle tick assertion assumes a reference strobe never stays high for two consecutive cycles. The bench always separates strobes with at least one idle cycle. The stall assertion assumes the consumer may hold `tag_ready` low for any length of time. The bench does exactly that while it keeps advancing the counter underneath.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int DAY_W  = 9;
  localparam int HOUR_W = 5;
  localparam int MIN_W  = 6;
  localparam int SEC_W  = 6;
  localparam int USEC_W = 20;
  localparam int WORD_W = 32;

  localparam int DAY_MIN  = 1;
  localparam int DAY_MAX  = 366;
  localparam int HOUR_MAX = 23;
  localparam int MIN_MAX  = 59;
  localparam int SEC_MAX  = 59;
  localparam int USEC_MAX = 999_999;

  localparam int HI_USED = DAY_W + HOUR_W + MIN_W;
  localparam int LO_USED = SEC_W + USEC_W;

  typedef struct packed {
    logic [DAY_W-1:0]  day;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
    logic [USEC_W-1:0] usec;
  } tag_t;

  function automatic logic [WORD_W-1:0] pack_hi(tag_t t);
    return {{(WORD_W-HI_USED){1'b0}}, t.day, t.hour, t.min};
  endfunction

  function automatic logic [WORD_W-1:0] pack_lo(tag_t t);
    return {{(WORD_W-LO_USED){1'b0}}, t.sec, t.usec};
  endfunction
endpackage

// File: rtl/tt_tick_gen.sv
module tt_tick_gen #(
  parameter int REF_PER_US = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_sel,
  input  logic ref_int_stb,
  input  logic ref_bp_stb,
  input  logic restart,
  output logic us_tick
);
  localparam int CNT_W = (REF_PER_US > 1) ? $clog2(REF_PER_US) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_PER_US - 1);

  logic [CNT_W-1:0] phase_q;
  logic             stb_sel;

  assign stb_sel = ref_sel ? ref_bp_stb : ref_int_stb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
      us_tick <= 1'b0;
    end else begin
      us_tick <= 1'b0;
      if (restart) begin
        phase_q <= '0;
      end else if (stb_sel) begin
        if (phase_q == LAST) begin
          phase_q <= '0;
          us_tick <= 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    us_tick |=> !us_tick); // R2

  AST_RESTART_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !us_tick); // R6
endmodule

// File: rtl/tt_field.sv
module tt_field #(
  parameter int W    = 6,
  parameter int MINV = 0,
  parameter int MAXV = 59
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         carry
);
  localparam logic [W-1:0] LO = W'(MINV);
  localparam logic [W-1:0] HI = W'(MAXV);

  logic at_top;
  assign at_top = (val == HI);
  assign carry  = inc && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)      val <= LO;
    else if (clr)    val <= LO;
    else if (ld)     val <= ld_val;
    else if (inc)    val <= at_top ? LO : val + 1'b1;
  end

  AST_FIELD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (val >= LO) && (val <= HI)); // R4

  AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && at_top && !clr && !ld) |=> (val == LO)); // R3

  AST_FIELD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !at_top && !clr && !ld) |=> (val == $past(val) + 1'b1)); // R2
endmodule

// File: rtl/tt_tag_counter.sv
module tt_tag_counter
  import tt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic ext_sync,
  input  logic star_pulse,
  input  logic load_stb,
  input  tag_t load_tag,
  output tag_t tag,
  output logic restart
);
  logic star_eff;
  logic ld_eff;
  logic c_usec, c_sec, c_min, c_hour, c_day;

  assign star_eff = star_pulse && !ext_sync;
  assign ld_eff   = load_stb && !star_eff;
  assign restart  = star_eff || load_stb;

  tt_field #(.W(USEC_W), .MINV(0), .MAXV(USEC_MAX)) i_usec (
    .clk(clk), .rst_n(rst_n), .clr(star_eff), .ld(ld_eff),
    .ld_val(load_tag.usec), .inc(us_tick), .val(tag.usec), .carry(c_usec));

  tt_field #(.W(SEC_W), .MINV(0), .MAXV(SEC_MAX)) i_sec (
    .clk(clk), .rst_n(rst_n), .clr(star_eff), .ld(ld_eff),
    .ld_val(load_tag.sec), .inc(c_usec), .val(tag.sec), .carry(c_sec));

  tt_field #(.W(MIN_W), .MINV(0), .MAXV(MIN_MAX)) i_min (
    .clk(clk), .rst_n(rst_n), .clr(star_eff), .ld(ld_eff),
    .ld_val(load_tag.min), .inc(c_sec), .val(tag.min), .carry(c_min));

  tt_field #(.W(HOUR_W), .MINV(0), .MAXV(HOUR_MAX)) i_hour (
    .clk(clk), .rst_n(rst_n), .clr(star_eff), .ld(ld_eff),
    .ld_val(load_tag.hour), .inc(c_min), .val(tag.hour), .carry(c_hour));

  tt_field #(.W(DAY_W), .MINV(DAY_MIN), .MAXV(DAY_MAX)) i_day (
    .clk(clk), .rst_n(rst_n), .clr(star_eff), .ld(ld_eff),
    .ld_val(load_tag.day), .inc(c_hour), .val(tag.day), .carry(c_day));

  AST_STAR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (star_pulse && !ext_sync) |=>
      (tag.day == DAY_W'(DAY_MIN)) && (tag.hour == '0) && (tag.min == '0)
      && (tag.sec == '0) && (tag.usec == '0)); // R7

  AST_STAR_IGNORED_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (star_pulse && ext_sync && !load_stb && !us_tick) |=> $stable(tag)); // R8

  AST_STAR_BEATS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (star_pulse && !ext_sync && load_stb) |=>
      (tag.day == DAY_W'(DAY_MIN)) && (tag.usec == '0)); // R9

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !(star_pulse && !ext_sync)) |=> (tag == $past(load_tag))); // R6

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (c_day && !restart) |=> (tag.day == DAY_W'(DAY_MIN))); // R5
endmodule

// File: rtl/tt_read_port.sv
module tt_read_port
  import tt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tag_t              tag,
  input  logic              rd_req,
  input  logic              tag_ready,
  output logic              tag_valid,
  output logic [WORD_W-1:0] tag_hi,
  output logic [WORD_W-1:0] tag_lo
);
  logic slot_free;
  assign slot_free = !tag_valid || tag_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_valid <= 1'b0;
      tag_hi    <= '0;
      tag_lo    <= '0;
    end else if (slot_free) begin
      tag_valid <= rd_req;
      if (rd_req) begin
        tag_hi <= pack_hi(tag);
        tag_lo <= pack_lo(tag);
      end
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_valid && !tag_ready) |=>
      (tag_valid && $stable(tag_hi) && $stable(tag_lo))); // R11

  AST_SNAPSHOT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && slot_free) |=>
      (tag_hi[10:0] == {$past(tag.hour), $past(tag.min)})
      && (tag_lo[19:0] == $past(tag.usec))); // R10
endmodule

// File: rtl/tt_timetag.sv
module tt_timetag
  import tt_pkg::*;
#(
  parameter int REF_PER_US = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_sel,
  input  logic        ref_int_stb,
  input  logic        ref_bp_stb,
  input  logic        ext_sync,
  input  logic        star_pulse,
  input  logic        load_stb,
  input  logic [8:0]  load_day,
  input  logic [4:0]  load_hour,
  input  logic [5:0]  load_min,
  input  logic [5:0]  load_sec,
  input  logic [19:0] load_usec,
  input  logic        rd_req,
  output logic        tag_valid,
  input  logic        tag_ready,
  output logic [31:0] tag_hi,
  output logic [31:0] tag_lo
);
  tag_t load_tag;
  tag_t cur_tag;
  logic us_tick;
  logic restart;

  assign load_tag = '{day: load_day, hour: load_hour, min: load_min,
                      sec: load_sec, usec: load_usec};

  tt_tick_gen #(.REF_PER_US(REF_PER_US)) i_tick (
    .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel),
    .ref_int_stb(ref_int_stb), .ref_bp_stb(ref_bp_stb),
    .restart(restart), .us_tick(us_tick));

  tt_tag_counter i_cnt (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .ext_sync(ext_sync),
    .star_pulse(star_pulse), .load_stb(load_stb), .load_tag(load_tag),
    .tag(cur_tag), .restart(restart));

  tt_read_port i_rd (
    .clk(clk), .rst_n(rst_n), .tag(cur_tag), .rd_req(rd_req),
    .tag_ready(tag_ready), .tag_valid(tag_valid),
    .tag_hi(tag_hi), .tag_lo(tag_lo));

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !tag_valid); // R1
endmodule

// File: tb/test_tt_timetag.sv
module test_tt_timetag;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_sel = 1'b0, ref_int_stb = 1'b0, ref_bp_stb = 1'b0;
  logic        ext_sync = 1'b0, star_pulse = 1'b0, load_stb = 1'b0;
  logic [8:0]  load_day = '0;
  logic [4:0]  load_hour = '0;
  logic [5:0]  load_min = '0, load_sec = '0;
  logic [19:0] load_usec = '0;
  logic        rd_req = 1'b0, tag_ready = 1'b0;
  logic        tag_valid;
  logic [31:0] tag_hi, tag_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tt_timetag i_tt_timetag (
    .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .ref_int_stb(ref_int_stb),
    .ref_bp_stb(ref_bp_stb), .ext_sync(ext_sync), .star_pulse(star_pulse),
    .load_stb(load_stb), .load_day(load_day), .load_hour(load_hour),
    .load_min(load_min), .load_sec(load_sec), .load_usec(load_usec),
    .rd_req(rd_req), .tag_valid(tag_valid), .tag_ready(tag_ready),
    .tag_hi(tag_hi), .tag_lo(tag_lo));

  function automatic logic [31:0] exp_hi(int d, int h, int m);
    return (32'(d) << 11) | (32'(h) << 6) | 32'(m);
  endfunction

  function automatic logic [31:0] exp_lo(int s, int u);
    return (32'(s) << 20) | 32'(u);
  endfunction

  task automatic check32(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic read_expect(string req, int d, int h, int m, int s, int u);
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    check1(req, "tag_valid after request", tag_valid, 1'b1);
    check32(req, "tag_hi", tag_hi, exp_hi(d, h, m));
    check32(req, "tag_lo", tag_lo, exp_lo(s, u));
    tag_ready = 1'b1;
    @(negedge clk) tag_ready = 1'b0;
  endtask

  task automatic strobes(int n, bit bp);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bp) ref_bp_stb = 1'b1; else ref_int_stb = 1'b1;
      @(negedge clk);
      ref_bp_stb = 1'b0;
      ref_int_stb = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic preset(int d, int h, int m, int s, int u);
    @(negedge clk);
    load_day = 9'(d); load_hour = 5'(h); load_min = 6'(m);
    load_sec = 6'(s); load_usec = 20'(u); load_stb = 1'b1;
    @(negedge clk) load_stb = 1'b0;
  endtask

  task automatic star_once();
    @(negedge clk) star_pulse = 1'b1;
    @(negedge clk) star_pulse = 1'b0;
  endtask

  task automatic t_reset();
    check1("R1", "tag_valid after reset", tag_valid, 1'b0);
    read_expect("R1", 1, 0, 0, 0, 0);
  endtask

  task automatic t_tick();
    strobes(10, 1'b0);
    read_expect("R2", 1, 0, 0, 0, 1);
    strobes(9, 1'b0);
    read_expect("R2", 1, 0, 0, 0, 1);
    strobes(20, 1'b1);   // unselected reference: no effect
    read_expect("R2", 1, 0, 0, 0, 1);
    ref_sel = 1'b1;
    strobes(1, 1'b1);
    read_expect("R2", 1, 0, 0, 0, 2);
    strobes(15, 1'b0);   // now on-board strobes are unselected
    read_expect("R2", 1, 0, 0, 0, 2);
    ref_sel = 1'b0;
  endtask

  task automatic t_load();
    preset(100, 12, 34, 56, 123456);
    read_expect("R6", 100, 12, 34, 56, 123456);
    read_expect("R10", 100, 12, 34, 56, 123456);
    strobes(9, 1'b0);
    preset(7, 1, 2, 3, 4);
    strobes(9, 1'b0);    // phase restarted by load: still no tick
    read_expect("R6", 7, 1, 2, 3, 4);
    strobes(1, 1'b0);
    read_expect("R6", 7, 1, 2, 3, 5);
  endtask

  task automatic t_usec_wrap();
    preset(5, 3, 7, 10, 999999);
    strobes(10, 1'b0);
    read_expect("R3", 5, 3, 7, 11, 0);
  endtask

  task automatic t_cascade();
    preset(200, 23, 59, 59, 999999);
    strobes(10, 1'b0);
    read_expect("R4", 201, 0, 0, 0, 0);
    preset(42, 9, 59, 59, 999999);
    strobes(10, 1'b0);
    read_expect("R4", 42, 10, 0, 0, 0);
  endtask

  task automatic t_day_wrap();
    preset(366, 23, 59, 59, 999999);
    strobes(10, 1'b0);
    read_expect("R5", 1, 0, 0, 0, 0);
  endtask

  task automatic t_star_free();
    ext_sync = 1'b0;
    preset(300, 18, 45, 30, 500000);
    strobes(5, 1'b0);
    star_once();
    read_expect("R7", 1, 0, 0, 0, 0);
    strobes(9, 1'b0);
    read_expect("R7", 1, 0, 0, 0, 0);
    strobes(1, 1'b0);
    read_expect("R7", 1, 0, 0, 0, 1);
  endtask

  task automatic t_star_sync();
    preset(150, 6, 20, 40, 777);
    ext_sync = 1'b1;
    star_once();
    read_expect("R8", 150, 6, 20, 40, 777);
    ext_sync = 1'b0;
  endtask

  task automatic t_star_vs_load();
    preset(60, 2, 3, 4, 5);
    @(negedge clk);
    load_day = 9'd250; load_hour = 5'd20; load_min = 6'd10;
    load_sec = 6'd9; load_usec = 20'd8;
    load_stb = 1'b1; star_pulse = 1'b1;
    @(negedge clk) load_stb = 1'b0; star_pulse = 1'b0;
    read_expect("R9", 1, 0, 0, 0, 0);
  endtask

  task automatic t_backpressure();
    preset(10, 11, 12, 13, 14);
    @(negedge clk) rd_req = 1'b1;
    @(negedge clk) rd_req = 1'b0;
    strobes(10, 1'b0);
    @(negedge clk) rd_req = 1'b1;   // dropped while stalled
    @(negedge clk) rd_req = 1'b0;
    check1("R11", "valid held under stall", tag_valid, 1'b1);
    check32("R11", "tag_hi held", tag_hi, exp_hi(10, 11, 12));
    check32("R11", "tag_lo held", tag_lo, exp_lo(13, 14));
    tag_ready = 1'b1;
    @(negedge clk) tag_ready = 1'b0;
    check1("R11", "valid drops after accept", tag_valid, 1'b0);
    read_expect("R11", 10, 11, 12, 13, 15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tick();
    t_load();
    t_usec_wrap();
    t_cascade();
    t_day_wrap();
    t_star_free();
    t_star_sync();
    t_star_vs_load();
    t_backpressure();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule